// File: doc/BRIEF.md
# Alarm and Hourly Chime Unit

This unit keeps one alarm time, an hour and a minute in two-digit BCD, and compares it with the running time of day that a separate timekeeping block supplies. When the alarm is armed, the clock is running and the time of day reaches the stored hour and minute, the alarm lamp turns on. It turns off by itself once the minute has passed, or at the next clock edge when the alarm is disarmed. While the clock is stopped and the alarm-set mode is selected, each one-second tick advances the stored hour, the stored minute, or both. The stored time is also driven out so that a display can show it.

The second output is an hourly chime lamp. During the first minute of every hour, when the minutes read 00, it blinks once per second. The number of blinks equals the current hour, so at 03:00 it gives three blinks and at midnight none. Each blink lasts for the high half of the one-second square wave.

All pins are plain level controls and status. No data stream crosses the block boundary, so there is no valid/ready handshake and no back-pressure. The one-second timing input is a square wave on the block clock, and each of its rising edges counts as one tick.

Top module: `alarm_chime_unit`

## Requirements
- R1: The stored alarm time changes only on a tick (a rising edge of `sec_phase`) while `alarm_set` is 1 and `run_en` is 0. In that case each tick advances the hour by one when `hour_req` is 1 and the minute by one when `min_req` is 1. Both may advance on the same tick.
- R2: Hours and minutes are BCD, with the tens digit in bits [7:4] and the units digit in bits [3:0]. The stored hour steps from 23 to 00 and the stored minute steps from 59 to 00.
- R3: `alarm_led` is 1 at the clock edge after a cycle in which `alarm_en`, `run_en`, hour equality and minute equality all hold. It is 0 after any cycle in which one of these four terms fails, including a cycle where only the hour differs.
- R4: The alarm lamp turns off one clock after the current minute moves past the stored minute. No action by the user is needed.
- R5: When `alarm_en` drops while the lamp is lit, the lamp is dark at the next clock edge.
- R6: While `cur_min` reads 00, the chime lamp blinks once per tick until it has blinked N times, where N is tens×10 + units of `cur_hour`. Further ticks in that minute give no blinks.
- R7: An hour of 00 gives no chime blinks.
- R8: A blink lights `chime_led` one clock after `sec_phase` rises and clears it one clock after `sec_phase` falls, so the lamp is lit for the high half of each tick period.
- R9: The blink count restarts whenever `cur_min` is not 00, so a fresh 00 minute gives the full number of blinks again.
- R10: While `clr_n` is 0, the stored alarm time is 00:00 and both lamps are off. This clear takes effect without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| sec_phase | input | 1 | One-second square wave; each rising edge is a tick |
| run_en | input | 1 | Time of day is running |
| alarm_en | input | 1 | Alarm armed |
| alarm_set | input | 1 | Alarm-set mode |
| hour_req | input | 1 | Advance the stored hour on each tick in set mode |
| min_req | input | 1 | Advance the stored minute on each tick in set mode |
| cur_hour | input | 8 | Current hour, BCD |
| cur_min | input | 8 | Current minute, BCD |
| alarm_led | output | 1 | Alarm lamp |
| chime_led | output | 1 | Hourly chime lamp |
| alarm_hour | output | 8 | Stored alarm hour, BCD |
| alarm_min | output | 8 | Stored alarm minute, BCD |

## Verification
The stored time is stepped all the way to 23 and 59 and then one step further. This shows whether the wrap is correct and whether the digits stay in BCD. The alarm comparison is tried with a miss on the minute only, a miss on the hour only, the minute after the match, a disarm and a stopped clock, so each of the four gating terms is seen failing on its own. The chime is run at hours 03, 12 and 00. Hour 12 separates a correct BCD-to-count conversion from a plain binary reading of the hour. A chime is also broken off by a nonzero minute and then restarted, which shows whether the blink count is cleared.

// File: rtl/alarm_chime_pkg.sv
package alarm_chime_pkg;

  typedef logic [7:0] bcd2_t;

  function automatic int unsigned bcd_to_bin(bcd2_t v);
    return 32'(v[7:4]) * 10 + 32'(v[3:0]);
  endfunction

  function automatic bcd2_t bin_to_bcd(int unsigned b);
    bcd2_t r;
    r[7:4] = 4'(b / 10);
    r[3:0] = 4'(b % 10);
    return r;
  endfunction

  // advance a two-digit BCD value by one, wrapping at modulus
  function automatic bcd2_t bcd_step(bcd2_t v, int unsigned modulus);
    int unsigned n;
    n = bcd_to_bin(v) + 1;
    if (n >= modulus) n = 0;
    return bin_to_bcd(n);
  endfunction

  function automatic logic bcd_legal(bcd2_t v, int unsigned modulus);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (bcd_to_bin(v) < modulus);
  endfunction

endpackage

// File: rtl/tick_edge.sv
module tick_edge (
  input  logic clk,
  input  logic clr_n,
  input  logic phase_in,
  output logic phase_q,
  output logic tick
);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) phase_q <= 1'b0;
    else        phase_q <= phase_in;
  end

  assign tick = phase_in & ~phase_q;

endmodule

// File: rtl/alarm_time_reg.sv
module alarm_time_reg
  import alarm_chime_pkg::*;
#(
  parameter int unsigned HOURS   = 24,
  parameter int unsigned MINUTES = 60
) (
  input  logic  clk,
  input  logic  clr_n,
  input  logic  tick,
  input  logic  run_en,
  input  logic  set_mode,
  input  logic  hour_req,
  input  logic  min_req,
  output bcd2_t alarm_hour,
  output bcd2_t alarm_min
);

  logic step_ok;
  assign step_ok = tick & set_mode & ~run_en;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      alarm_hour <= '0;
      alarm_min  <= '0;
    end else if (step_ok) begin
      if (hour_req) alarm_hour <= bcd_step(alarm_hour, HOURS);
      if (min_req)  alarm_min  <= bcd_step(alarm_min, MINUTES);
    end
  end

  AST_SET_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
    (!set_mode || run_en || !tick) |=> ($stable(alarm_hour) && $stable(alarm_min))); // R1

  AST_HOUR_LEGAL: assert property (@(posedge clk) disable iff (!clr_n)
    bcd_legal(alarm_hour, HOURS)); // R2

  AST_MIN_LEGAL: assert property (@(posedge clk) disable iff (!clr_n)
    bcd_legal(alarm_min, MINUTES)); // R2

endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_chime_pkg::*;
(
  input  logic  clk,
  input  logic  clr_n,
  input  logic  alarm_en,
  input  logic  run_en,
  input  bcd2_t cur_hour,
  input  bcd2_t cur_min,
  input  bcd2_t alarm_hour,
  input  bcd2_t alarm_min,
  output logic  alarm_led
);

  logic same_time;
  assign same_time = (cur_hour == alarm_hour) && (cur_min == alarm_min);

  // level compare: the lamp follows the match, so it drops once the minute moves on
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) alarm_led <= 1'b0;
    else        alarm_led <= alarm_en & run_en & same_time;
  end

  AST_ALARM_ON: assert property (@(posedge clk) disable iff (!clr_n)
    (alarm_en && run_en && cur_hour == alarm_hour && cur_min == alarm_min) |=> alarm_led); // R3

  AST_ALARM_DISARM: assert property (@(posedge clk) disable iff (!clr_n)
    !alarm_en |=> !alarm_led); // R5

  AST_ALARM_PASSED: assert property (@(posedge clk) disable iff (!clr_n)
    (cur_min != alarm_min) |=> !alarm_led); // R4

endmodule

// File: rtl/chime_seq.sv
module chime_seq
  import alarm_chime_pkg::*;
#(
  parameter int unsigned HOURS = 24
) (
  input  logic  clk,
  input  logic  clr_n,
  input  logic  tick,
  input  logic  phase_q,
  input  bcd2_t cur_hour,
  input  bcd2_t cur_min,
  output logic  chime_led
);

  localparam int unsigned CNT_W = $clog2(HOURS + 1);

  logic [CNT_W-1:0] hour_bin;
  logic [CNT_W-1:0] cnt;
  logic             slot;
  logic             min_zero;

  assign min_zero = (cur_min == 8'h00);
  assign hour_bin = bcd_legal(cur_hour, HOURS) ? CNT_W'(bcd_to_bin(cur_hour)) : '0;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      cnt  <= '0;
      slot <= 1'b0;
    end else if (!min_zero) begin
      cnt  <= '0;
      slot <= 1'b0;
    end else if (tick) begin
      if (cnt < hour_bin) begin
        cnt  <= cnt + CNT_W'(1);
        slot <= 1'b1;
      end else begin
        slot <= 1'b0;
      end
    end
  end

  assign chime_led = slot & phase_q;

  AST_CHIME_CNT_CLR: assert property (@(posedge clk) disable iff (!clr_n)
    !min_zero |=> (cnt == '0)); // R9

  AST_CHIME_CNT_CAP: assert property (@(posedge clk) disable iff (!clr_n)
    cnt <= CNT_W'(HOURS - 1)); // R6

  AST_CHIME_HOUR0: assert property (@(posedge clk) disable iff (!clr_n)
    (min_zero && cur_hour == 8'h00 && $stable(cur_hour) && cnt == '0) |=> (cnt == '0)); // R7

endmodule

// File: rtl/alarm_chime_unit.sv
module alarm_chime_unit
  import alarm_chime_pkg::*;
#(
  parameter int unsigned HOURS_PER_DAY = 24,
  parameter int unsigned MINS_PER_HOUR = 60
) (
  input  logic       clk,
  input  logic       clr_n,
  input  logic       sec_phase,
  input  logic       run_en,
  input  logic       alarm_en,
  input  logic       alarm_set,
  input  logic       hour_req,
  input  logic       min_req,
  input  logic [7:0] cur_hour,
  input  logic [7:0] cur_min,
  output logic       alarm_led,
  output logic       chime_led,
  output logic [7:0] alarm_hour,
  output logic [7:0] alarm_min
);

  logic phase_q;
  logic tick;

  tick_edge u_tick (
    .clk      (clk),
    .clr_n    (clr_n),
    .phase_in (sec_phase),
    .phase_q  (phase_q),
    .tick     (tick)
  );

  alarm_time_reg #(
    .HOURS   (HOURS_PER_DAY),
    .MINUTES (MINS_PER_HOUR)
  ) u_time (
    .clk        (clk),
    .clr_n      (clr_n),
    .tick       (tick),
    .run_en     (run_en),
    .set_mode   (alarm_set),
    .hour_req   (hour_req),
    .min_req    (min_req),
    .alarm_hour (alarm_hour),
    .alarm_min  (alarm_min)
  );

  alarm_match u_match (
    .clk        (clk),
    .clr_n      (clr_n),
    .alarm_en   (alarm_en),
    .run_en     (run_en),
    .cur_hour   (cur_hour),
    .cur_min    (cur_min),
    .alarm_hour (alarm_hour),
    .alarm_min  (alarm_min),
    .alarm_led  (alarm_led)
  );

  chime_seq #(
    .HOURS (HOURS_PER_DAY)
  ) u_chime (
    .clk       (clk),
    .clr_n     (clr_n),
    .tick      (tick),
    .phase_q   (phase_q),
    .cur_hour  (cur_hour),
    .cur_min   (cur_min),
    .chime_led (chime_led)
  );

  AST_CHIME_DARK_LOW: assert property (@(posedge clk) disable iff (!clr_n)
    !sec_phase |=> !chime_led); // R8

  AST_CLEAR_STATE: assert property (@(posedge clk)
    !clr_n |-> (!alarm_led && !chime_led && alarm_hour == 8'h00 && alarm_min == 8'h00)); // R10

endmodule

// File: tb/alarm_chime_unit_tb.sv
module alarm_chime_unit_tb;

  localparam int HALF = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       clr_n, sec_phase, run_en, alarm_en, alarm_set, hour_req, min_req;
  logic [7:0] cur_hour, cur_min;
  wire        alarm_led, chime_led;
  wire  [7:0] alarm_hour, alarm_min;

  alarm_chime_unit u_dut (
    .clk        (clk),
    .clr_n      (clr_n),
    .sec_phase  (sec_phase),
    .run_en     (run_en),
    .alarm_en   (alarm_en),
    .alarm_set  (alarm_set),
    .hour_req   (hour_req),
    .min_req    (min_req),
    .cur_hour   (cur_hour),
    .cur_min    (cur_min),
    .alarm_led  (alarm_led),
    .chime_led  (chime_led),
    .alarm_hour (alarm_hour),
    .alarm_min  (alarm_min)
  );

  typedef struct {
    string rq;
    int    sel;
    int    val;
  } exp_t;

  exp_t sb[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   blinks   = 0;
  int   lit      = 0;
  logic prev_chime = 1'b0;
  bit   done = 1'b0;

  function automatic int observe(int sel);
    case (sel)
      0: return int'(alarm_led);
      1: return int'(chime_led);
      2: return int'(alarm_hour);
      3: return int'(alarm_min);
      4: return blinks;
      default: return lit;
    endcase
  endfunction

  // blink counter, sampled away from the active edge
  always @(negedge clk) begin
    if (chime_led && !prev_chime) blinks++;
    if (chime_led) lit++;
    prev_chime = chime_led;
  end

  // monitor: pops expected items and compares with what the design shows
  always @(negedge clk) begin
    #1;
    while (sb.size() > 0) begin
      exp_t e;
      int   got;
      e = sb.pop_front();
      got = observe(e.sel);
      n_checks++;
      if (got != e.val) begin
        n_fail++;
        $display("FAIL %s sel=%0d actual=%0h expected=%0h", e.rq, e.sel, got, e.val);
      end
    end
  end

  task automatic expect_item(string rq, int sel, int val);
    exp_t e;
    e.rq = rq; e.sel = sel; e.val = val;
    sb.push_back(e);
    @(negedge clk); #2;
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      sec_phase = 1'b1;
      wait_clk(HALF);
      sec_phase = 1'b0;
      wait_clk(HALF);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  task automatic chime_run(logic [7:0] hr, int ticks);
    cur_min = 8'h05;
    wait_clk(2);
    cur_hour = hr;
    cur_min  = 8'h00;
    blinks = 0; lit = 0;
    tick(ticks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    clr_n = 1'b0; sec_phase = 1'b0; run_en = 1'b0; alarm_en = 1'b0;
    alarm_set = 1'b0; hour_req = 1'b0; min_req = 1'b0;
    cur_hour = 8'h00; cur_min = 8'h01;
    wait_clk(3);
    expect_item("R10 reset alarm_led", 0, 0);
    expect_item("R10 reset chime_led", 1, 0);
    expect_item("R10 reset hour", 2, 'h00);
    expect_item("R10 reset min", 3, 'h00);
    clr_n = 1'b1;
    wait_clk(2);

    // R1 R2: step the stored time in set mode with the clock stopped
    alarm_set = 1'b1; hour_req = 1'b1;
    tick(23);
    expect_item("R1 hour stepped to 23", 2, 'h23);
    tick(1);
    expect_item("R2 hour wraps 23->00", 2, 'h00);
    tick(7);
    hour_req = 1'b0; min_req = 1'b1;
    tick(59);
    expect_item("R2 minute reaches 59 in BCD", 3, 'h59);
    tick(1);
    expect_item("R2 minute wraps 59->00", 3, 'h00);
    tick(30);
    expect_item("R1 hour holds while only minute steps", 2, 'h07);
    expect_item("R1 minute set", 3, 'h30);

    // R1: running clock blocks setting
    run_en = 1'b1; hour_req = 1'b1; min_req = 1'b1;
    tick(2);
    expect_item("R1 blocked while running hour", 2, 'h07);
    expect_item("R1 blocked while running min", 3, 'h30);
    run_en = 1'b0; alarm_set = 1'b0;
    tick(1);
    expect_item("R1 blocked outside set mode", 3, 'h30);
    hour_req = 1'b0; min_req = 1'b0;

    // alarm comparison
    run_en = 1'b1; alarm_en = 1'b1; cur_hour = 8'h07; cur_min = 8'h29;
    expect_item("R3 minute before match dark", 0, 0);
    cur_min = 8'h30;
    expect_item("R3 match lights lamp", 0, 1);
    cur_hour = 8'h17;
    expect_item("R3 hour mismatch dark", 0, 0);
    cur_hour = 8'h07;
    expect_item("R3 match again", 0, 1);
    cur_min = 8'h31;
    expect_item("R4 minute passed dark", 0, 0);
    cur_min = 8'h30;
    wait_clk(1);
    alarm_en = 1'b0;
    expect_item("R5 disarm clears lamp", 0, 0);
    alarm_en = 1'b1;
    wait_clk(1);
    run_en = 1'b0;
    expect_item("R3 stopped clock dark", 0, 0);
    alarm_en = 1'b0; run_en = 1'b1;

    // chime
    chime_run(8'h03, 6);
    expect_item("R6 hour 03 gives 3 blinks", 4, 3);
    expect_item("R8 lit for half period per blink", 5, 3 * HALF);
    chime_run(8'h12, 14);
    expect_item("R6 hour 12 read as BCD gives 12 blinks", 4, 12);
    chime_run(8'h00, 3);
    expect_item("R7 hour 00 no blinks", 4, 0);
    chime_run(8'h05, 2);
    expect_item("R9 partial chime", 4, 2);
    cur_min = 8'h01;
    wait_clk(2);
    cur_min = 8'h00;
    tick(7);
    expect_item("R9 count restarts after nonzero minute", 4, 7);

    // R10: clear mid-operation
    cur_hour = 8'h07; cur_min = 8'h30; alarm_en = 1'b1;
    wait_clk(1);
    expect_item("R10 precondition lamp lit", 0, 1);
    clr_n = 1'b0;
    expect_item("R10 clear lamp", 0, 0);
    expect_item("R10 clear hour", 2, 'h00);
    expect_item("R10 clear min", 3, 'h00);
    clr_n = 1'b1;
    wait_clk(2);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule